// File: doc/BRIEF.md
# Stereo Serial Audio Transmitter

This block sends a stereo pair of 16-bit samples over a three-wire serial audio link: a bit clock, a word strobe and a data line. It divides the system clock internally to make the bit clock. It sends the left word while the strobe is low and the right word while the strobe is high. Each word goes out most significant bit first. The strobe changes one bit clock ahead of each word's first bit. A single 8-bit divider value N sets the bit clock to the system clock divided by 2(N+1). A full frame therefore takes 32 bit clocks, or 64(N+1) system clocks.

A host loads the left sample, the right sample, the divider and a mode word through one write port. The shift register takes each sample at the start of that channel's slot, so a sample written mid-slot is sent in the next frame. An interrupt flag can be set on a rising strobe edge, on a falling strobe edge, or at the first bit of every word. The flag stays set until the host clears it. A two-bit status output reports the strobe level and whether a left word is being sent.

Top module: `i2s_stereo_tx`

## Requirements
- R1: While enabled, the bit clock has a period of exactly 2(N+1) system clocks, half high and half low, where N is the divider (written with wr_addr = 2, taken from wr_data[7:0]).
- R2: After reset all outputs are low and the divider holds 8, so enabling without a divider write gives an 18-cycle bit clock.
- R3: A frame is 32 bit clocks. Data changes on the falling bit clock edge. The left word (wr_addr = 0) is sent MSB first while the strobe is low, then the right word (wr_addr = 1) while it is high. The strobe changes on the falling edge that sends the last bit of the previous word, and its period is 64(N+1) system clocks.
- R4: Each sample register is copied into the shifter as its slot begins. A write during a slot changes only the word of the next frame.
- R5: A divider write restarts the timing: in the next cycle the bit clock and strobe are low, the frame restarts at the left word, and the first rising bit clock edge follows N+1 cycles later.
- R6: Mode word (wr_addr = 3, wr_data[5:0]): bit 0 enables the clock. While it is clear, the bit clock, strobe and data stay low and the timing is held at the frame start.
- R7: Mode bit 2 enables the strobe. While it is clear the strobe output stays low, and strobe-edge interrupts do not occur.
- R8: Mode bit 3 sets the interrupt flag on each rising strobe edge. Mode bit 4 sets it on each falling strobe edge. The flag goes high in the same cycle as the edge.
- R9: Mode bit 5 sets the interrupt flag as the first bit of every word is sent, twice per frame.
- R10: The interrupt flag stays set until irq_clr is high at a clock edge. If a set event and a clear fall in the same cycle, the set wins.
- R11: status[0] equals the strobe output. status[1] is high while a left word is being sent, which is 32(N+1) cycles of each frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register select: 0 left, 1 right, 2 divider, 3 mode |
| wr_data | input | 16 | Write data |
| irq_clr | input | 1 | Clears the interrupt flag |
| sck | output | 1 | Bit clock |
| ws | output | 1 | Word strobe, low for left |
| sd | output | 1 | Serial data |
| irq | output | 1 | Sticky interrupt flag |
| status | output | 2 | {left word active, strobe level} |

## Verification
The interrupt flag has one set path and one clear path, and the two can act in the same clock edge. The bench holds irq_clr high throughout a frame in every-word mode, so each word-start event coincides with an active clear. It then expects the flag high for exactly one sample per event, two per frame, and never on two samples in a row. A second coincidence is a divider write landing in the middle of a frame while the strobe is high. There the bench requires the strobe and bit clock low in the next cycle and times the first rising edge that follows.

// File: rtl/i2s_stereo_tx.sv
module i2s_stereo_tx #(
  parameter int DW      = 16,
  parameter int CW      = 8,
  parameter int MW      = 6,
  parameter int DIV_RST = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [1:0]    wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic          irq_clr,
  output logic          sck,
  output logic          ws,
  output logic          sd,
  output logic          irq,
  output logic [1:0]    status
);
  localparam int BW = $clog2(2*DW);
  localparam logic [BW-1:0] LAST = BW'(2*DW-1);
  localparam logic [BW-1:0] HALF = BW'(DW);

  logic [DW-1:0] left_q, right_q, sh_q;
  logic [CW-1:0] div_q, cnt_q;
  logic [MW-1:0] mode_q;
  logic [BW-1:0] bit_q, bit_nx;
  logic          sck_q, irq_q;

  function automatic logic strobe_of(input logic [BW-1:0] b);
    return (b >= HALF - 1'b1) && (b != LAST);
  endfunction

  wire en        = mode_q[0];
  wire ws_en     = mode_q[2];
  wire div_wr    = wr_en && (wr_addr == 2'd2);
  wire restart   = !en || div_wr;
  wire half_tick = (cnt_q == div_q);
  wire fall_tick = half_tick && sck_q && !restart;

  assign bit_nx = (bit_q == LAST) ? '0 : bit_q + 1'b1;

  wire ws_now  = strobe_of(bit_q);
  wire ws_next = strobe_of(bit_nx);
  wire ev_rise = ws_en && mode_q[3] && !ws_now && ws_next;
  wire ev_fall = ws_en && mode_q[4] && ws_now && !ws_next;
  wire ev_word = mode_q[5] && (bit_nx == '0 || bit_nx == HALF);
  wire irq_set = fall_tick && (ev_rise || ev_fall || ev_word);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      left_q  <= '0;
      right_q <= '0;
      div_q   <= CW'(DIV_RST);
      mode_q  <= '0;
    end else if (wr_en) begin
      case (wr_addr)
        2'd0: left_q  <= wr_data;
        2'd1: right_q <= wr_data;
        2'd2: div_q   <= wr_data[CW-1:0];
        default: mode_q <= wr_data[MW-1:0];
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      sck_q <= 1'b0;
      bit_q <= LAST;
      sh_q  <= '0;
    end else if (restart) begin
      cnt_q <= '0;
      sck_q <= 1'b0;
      bit_q <= LAST;
      sh_q  <= '0;
    end else if (half_tick) begin
      cnt_q <= '0;
      sck_q <= !sck_q;
      if (sck_q) begin
        bit_q <= bit_nx;
        if (bit_nx == '0)       sh_q <= left_q;
        else if (bit_nx == HALF) sh_q <= right_q;
        else                    sh_q <= {sh_q[DW-2:0], 1'b0};
      end
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       irq_q <= 1'b0;
    else if (irq_set) irq_q <= 1'b1;
    else if (irq_clr) irq_q <= 1'b0;
  end

  assign sck    = sck_q;
  assign ws     = ws_now && ws_en;
  assign sd     = sh_q[DW-1];
  assign irq    = irq_q;
  assign status = {en && (bit_q < HALF), ws};
endmodule

// File: rtl/i2s_stereo_tx_checker.sv
module i2s_stereo_tx_checker #(
  parameter int CW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          wr_en,
  input logic          irq_clr,
  input logic          sck,
  input logic          ws,
  input logic          sd,
  input logic          irq,
  input logic          en,
  input logic [CW-1:0] cnt,
  input logic [CW-1:0] div
);
  assert_sck_toggle_at_limit_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sck) |-> ($past(cnt) == $past(div)) || $past(wr_en) || !$past(en));

  assert_ws_moves_on_fall_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(ws) |-> $fell(sck) || $past(wr_en) || !$past(en));

  assert_sd_moves_on_fall_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sd) |-> $fell(sck) || $past(wr_en) || !$past(en));

  assert_quiet_when_off_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !en && !$past(en) |-> !sck && !ws && !sd);

  assert_irq_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
    irq && !irq_clr |=> irq);
endmodule

bind i2s_stereo_tx i2s_stereo_tx_checker #(.CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .irq_clr(irq_clr),
  .sck(sck), .ws(ws), .sd(sd), .irq(irq),
  .en(mode_q[0]), .cnt(cnt_q), .div(div_q)
);

// File: tb/tb_i2s_stereo_tx.sv
module tb_i2s_stereo_tx;
  logic clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0, irq_clr = 1'b0;
  logic [1:0] wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic sck, ws, sd, irq;
  logic [1:0] status;

  int checks = 0, errors = 0, cyc = 0;
  localparam int EN = 1, WSE = 4, RIS = 8, FAL = 16, EVW = 32;

  i2s_stereo_tx dut (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .irq_clr(irq_clr), .sck(sck), .ws(ws), .sd(sd),
    .irq(irq), .status(status));

  always #10 clk = !clk;

  // serial decoder, samples at each rising bit clock
  logic psck = 1'b0, lws = 1'b0;
  logic [15:0] acc = '0, last_l = '0, last_r = '0;
  int nb = 0, lc = 0, rc = 0;
  always @(negedge clk) begin
    if (sck && !psck) begin
      acc = {acc[14:0], sd};
      nb++;
      if (ws != lws) begin
        if (nb >= 16) begin
          if (lws) begin last_r = acc; rc++; end
          else     begin last_l = acc; lc++; end
        end
        nb = 0;
        lws = ws;
      end
    end
    psck = sck;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input int d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a[1:0]; wr_data = d[15:0];
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic clr_pulse;
    @(negedge clk); irq_clr = 1'b1;
    @(negedge clk); irq_clr = 1'b0;
  endtask

  task automatic setup(input int n, input int l, input int r, input int mode);
    wr(3, 0); wr(2, n); wr(0, l); wr(1, r); wr(3, mode);
  endtask

  task automatic sck_period(output int k);
    while (sck) @(negedge clk);
    while (!sck) @(negedge clk);
    k = 0;
    while (sck) begin @(negedge clk); k++; end
    while (!sck) begin @(negedge clk); k++; end
  endtask

  task automatic t_reset;
    @(negedge clk);
    check("R2 reset outputs", {28'd0, sck, ws, sd, irq}, 0);
    check("R2 reset status", status, 0);
  endtask

  task automatic t_default_div;
    int k;
    wr(3, EN);
    sck_period(k);
    check("R2 default divider period", k, 18);
  endtask

  task automatic t_period(input int n);
    int k;
    setup(n, 0, 0, EN);
    sck_period(k);
    check("R1 bit clock period", k, 2*(n+1));
  endtask

  task automatic t_frame(input int n, input int l, input int r);
    int c, k, bad, act;
    setup(n, l, r, EN | WSE);
    c = lc; while (lc == c) @(negedge clk);
    check("R3 left word", last_l, l);
    c = rc; while (rc == c) @(negedge clk);
    check("R3 right word", last_r, r);
    while (ws) @(negedge clk);
    while (!ws) @(negedge clk);
    k = 0; bad = 0; act = 0;
    while (ws) begin @(negedge clk); k++; if (status[0] != ws) bad++; if (status[1]) act++; end
    while (!ws) begin @(negedge clk); k++; if (status[0] != ws) bad++; if (status[1]) act++; end
    check("R3 strobe period", k, 64*(n+1));
    check("R11 status strobe mismatches", bad, 0);
    check("R11 left active cycles", act, 32*(n+1));
  endtask

  task automatic t_midwrite;
    int c;
    setup(1, 16'hA5C3, 16'h0F0F, EN | WSE);
    c = lc; while (lc == c) @(negedge clk);
    while (status[1]) @(negedge clk);
    while (!status[1]) @(negedge clk);
    wr(0, 16'h1234);
    c = lc; while (lc == c) @(negedge clk);
    check("R4 current slot keeps old sample", last_l, 16'hA5C3);
    c = lc; while (lc == c) @(negedge clk);
    check("R4 next frame takes new sample", last_l, 16'h1234);
  endtask

  task automatic t_restart;
    int k;
    setup(1, 16'hFFFF, 16'hFFFF, EN | WSE);
    while (!ws) @(negedge clk);
    repeat (3) @(negedge clk);
    wr(2, 3);
    check("R5 restart clears clock and strobe", {30'd0, sck, ws}, 0);
    check("R5 restart returns to frame start", status, 0);
    k = 0;
    while (!sck) begin @(negedge clk); k++; end
    check("R5 first rising edge delay", k, 4);
  endtask

  task automatic t_disable;
    int bad = 0;
    setup(0, 16'hFFFF, 16'hFFFF, EN | WSE);
    repeat (40) @(negedge clk);
    wr(3, 0);
    @(negedge clk);
    repeat (100) begin @(negedge clk); if (sck || ws || sd) bad++; end
    check("R6 outputs held low when disabled", bad, 0);
  endtask

  task automatic t_wsen_off;
    int wsh = 0, irqs = 0, ones = 0;
    setup(0, 16'hFFFF, 16'hFFFF, EN | RIS | FAL);
    clr_pulse();
    repeat (160) begin @(negedge clk); if (ws) wsh++; if (irq) irqs++; if (sd) ones++; end
    check("R7 strobe stays low", wsh, 0);
    check("R7 no strobe edge interrupt", irqs, 0);
    check("R7 data still shifts", ones > 0, 1);
  endtask

  task automatic t_edge_irq(input bit rising);
    int early = 0;
    setup(1, 0, 0, EN | WSE | (rising ? RIS : FAL));
    while (ws != rising) @(negedge clk);
    while (ws == rising) @(negedge clk);
    clr_pulse();
    while (ws != rising) begin if (irq) early++; @(negedge clk); end
    if (rising) begin
      check("R8 no set before rising edge", early, 0);
      check("R8 set with rising edge", irq, 1);
    end else begin
      check("R8 no set before falling edge", early, 0);
      check("R8 set with falling edge", irq, 1);
    end
  endtask

  task automatic t_word_irq;
    int n = 0;
    setup(1, 0, 0, EN | WSE | EVW);
    while (ws) @(negedge clk);
    while (!ws) @(negedge clk);
    clr_pulse();
    repeat (128) begin
      @(negedge clk);
      if (irq) n++;
      irq_clr = irq;
    end
    irq_clr = 1'b0;
    check("R9 word events per frame", n, 2);
  endtask

  task automatic t_setclr;
    int hi = 0, twice = 0, stay = 0;
    logic prev = 1'b0;
    setup(0, 0, 0, EN | WSE | EVW);
    @(negedge clk); irq_clr = 1'b1;
    @(negedge clk);
    repeat (64) begin
      @(negedge clk);
      if (irq) hi++;
      if (irq && prev) twice++;
      prev = irq;
    end
    irq_clr = 1'b0;
    check("R10 set wins over clear", hi, 2);
    check("R10 clear acts next cycle", twice, 0);
    while (!irq) @(negedge clk);
    wr(3, EN | WSE);
    repeat (80) begin @(negedge clk); if (irq) stay++; end
    check("R10 flag stays set", stay, 80);
    clr_pulse();
    check("R10 clear drops flag", irq, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_default_div();
    t_period(0);
    t_period(3);
    t_frame(1, 16'hA5C3, 16'h3C5A);
    t_frame(0, 16'h8001, 16'h7FFE);
    t_midwrite();
    t_restart();
    t_disable();
    t_wsen_off();
    t_edge_irq(1'b1);
    t_edge_irq(1'b0);
    t_word_irq();
    t_setclr();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule